// File: doc/BRIEF.md
# Dual-FIFO Instruction Queue with Fetch Replay

This block sits between the instruction realigner and the decoder. Each cycle it can take in a block of up to two predecoded instructions. Every instruction carries its instruction word and address, plus a control-flow class, an exception flag with a cause and a faulting address, and an optional predicted target. The instructions go into an eight-entry instruction FIFO. Predicted targets go into a separate two-entry target FIFO, and only instructions that carry a prediction write to it. The head instruction is handed to decode through a valid/ready handshake, one per cycle. When the instruction owns a prediction, its target comes from the head of the target FIFO.

The block applies no backpressure towards fetch. If a block cannot be taken as a whole, the block writes none of it. In that same cycle it raises a replay request and gives the address to fetch again. A flush empties both FIFOs at once.

Top module: `iq_queue`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `out_valid_o` and `replay_o` are low.
- R2: Accepted instructions leave in arrival order, with lane 0 ahead of lane 1. The word, address, class, exception flag, cause and faulting address are unchanged. One entry is removed on each cycle in which `out_valid_o` and `out_ready_i` are both high.
- R3: The instruction FIFO holds 8 entries (four per lane). A block of n kept instructions is accepted only if 8 minus the occupancy at the start of the cycle is at least n. A pop in the same cycle does not free space for that cycle.
- R4: When a block with at least one kept instruction is not accepted, `replay_o` is high in the same cycle. `replay_addr_o` then carries the address of the lowest-numbered kept lane, and no lane of that block is written.
- R5: The target FIFO holds 2 entries. A block that contains a kept predicted instruction is rejected (R4) when two predictions are already queued, even if the instruction FIFO has room. A block without a prediction is unaffected by a full target FIFO.
- R6: A valid lane at a higher index than a valid lane with `in_pred_i` set is dropped. It is neither queued nor counted for capacity.
- R7: `out_pred_valid_o` is high exactly when the head entry arrived with a prediction, and `out_pred_target_o` then carries that entry's target. Otherwise `out_pred_target_o` is zero.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the head entry stays presented and unchanged in the next cycle.
- R9: With `flush_i` high, both FIFOs are empty from the next cycle on. Incoming lanes in that cycle are discarded, and `replay_o` stays low.
- R10: A cycle with no valid lane never raises `replay_o`, even when both FIFOs are full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty both FIFOs, discard this cycle's block |
| in_valid_i | input | 2 | Per-lane valid |
| in_instr_i | input | 64 | Per-lane instruction word (lane i at bits 32i+31:32i) |
| in_addr_i | input | 64 | Per-lane instruction address |
| in_cf_i | input | 6 | Per-lane control-flow class, 3 bits each (0 none, 1 branch, 2 jump, 3 indirect jump, 4 return) |
| in_exc_i | input | 2 | Per-lane exception flag |
| in_exc_cause_i | input | 12 | Per-lane exception cause, 6 bits each |
| in_exc_tval_i | input | 64 | Per-lane faulting address |
| in_pred_i | input | 2 | Per-lane predicted-taken flag |
| in_pred_target_i | input | 64 | Per-lane predicted target |
| replay_o | output | 1 | Block rejected, fetch again |
| replay_addr_o | output | 32 | Address to fetch again |
| out_valid_o | output | 1 | Head entry present |
| out_ready_i | input | 1 | Decode takes the head entry |
| out_instr_o | output | 32 | Head instruction word |
| out_addr_o | output | 32 | Head instruction address |
| out_cf_o | output | 3 | Head control-flow class |
| out_exc_o | output | 1 | Head exception flag |
| out_exc_cause_o | output | 6 | Head exception cause |
| out_exc_tval_o | output | 32 | Head faulting address |
| out_pred_valid_o | output | 1 | Head carries a prediction |
| out_pred_target_o | output | 32 | Head predicted target, zero without prediction |

## Verification
Directed sequences push the queue to its edges. Occupancy seven followed by a two-wide block, then a one-wide block, separates rejection from acceptance at the exact free-space boundary. Two queued predictions followed first by a predicted block and then by a plain block show that the target FIFO gates only predicted blocks. A predicted lane 0 with a valid lane 1 shows the lanes after the prediction being dropped, and an empty block at full occupancy shows that no spurious replay is raised. Random traffic varies lane validity, prediction density, exceptions, decode readiness and flushes, and is compared cycle by cycle against a queue model. This separates correct ordering, pairing of targets with their owners, and stalls under a held head from off-by-one faults in pointers and counts.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned IQ_XLEN    = 32;
  localparam int unsigned IQ_ILEN    = 32;
  localparam int unsigned IQ_CAUSE_W = 6;
  localparam int unsigned IQ_CF_W    = 3;

  typedef enum logic [IQ_CF_W-1:0] {
    CF_NONE   = 3'd0,
    CF_BRANCH = 3'd1,
    CF_JUMP   = 3'd2,
    CF_IJUMP  = 3'd3,
    CF_RETURN = 3'd4
  } iq_cf_e;

  typedef struct packed {
    logic [IQ_ILEN-1:0]    instr;
    logic [IQ_XLEN-1:0]    addr;
    iq_cf_e                cf;
    logic                  exc;
    logic [IQ_CAUSE_W-1:0] cause;
    logic [IQ_XLEN-1:0]    tval;
    logic                  pred;
  } iq_entry_t;

  localparam int unsigned IQ_ENTRY_W = $bits(iq_entry_t);
endpackage

// File: rtl/iq_ring.sv
module iq_ring #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NPUSH = 2,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned NW   = $clog2(NPUSH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [NW-1:0]      push_n_i,
  input  logic [NPUSH*W-1:0] push_data_i,
  input  logic               pop_i,
  output logic [W-1:0]       head_o,
  output logic [CW-1:0]      count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] wrap(input int p);
    return (p >= int'(DEPTH)) ? PW'(p - int'(DEPTH)) : PW'(p);
  endfunction

  always_comb begin
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      wr_d  = wrap(int'(wr_q) + int'(push_n_i));
      rd_d  = pop_i ? wrap(int'(rd_q) + 1) : rd_q;
      cnt_d = cnt_q + CW'(push_n_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < int'(NPUSH); k++) begin
      if (!flush_i && (k < int'(push_n_i))) begin
        mem_q[wrap(int'(wr_q) + k)] <= push_data_i[k*W +: W];
      end
    end
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/iq_admit.sv
module iq_admit
  import iq_pkg::*;
#(
  parameter int unsigned LANES    = 2,
  parameter int unsigned IQ_DEPTH = 8,
  parameter int unsigned AQ_DEPTH = 2,
  localparam int unsigned NW      = $clog2(LANES + 1),
  localparam int unsigned ICW     = $clog2(IQ_DEPTH + 1),
  localparam int unsigned ACW     = $clog2(AQ_DEPTH + 1)
) (
  input  logic                          flush_i,
  input  logic [LANES-1:0]              valid_i,
  input  iq_entry_t                     lane_i [LANES],
  input  logic [LANES*IQ_XLEN-1:0]      target_i,
  input  logic [ICW-1:0]                iq_count_i,
  input  logic [ACW-1:0]                aq_count_i,
  output logic [NW-1:0]                 iq_push_n_o,
  output logic [LANES*IQ_ENTRY_W-1:0]   iq_push_data_o,
  output logic                          aq_push_o,
  output logic [IQ_XLEN-1:0]            aq_push_data_o,
  output logic                          replay_o,
  output logic [IQ_XLEN-1:0]            replay_addr_o
);
  logic [LANES-1:0] kept;
  logic             cut, has_pred, have_first, fits_iq, fits_aq, take;
  logic [NW-1:0]    n_kept;
  logic [IQ_XLEN-1:0] pred_tgt;
  iq_entry_t        packed_q [LANES];

  // Lanes after the first predicted lane are dropped; survivors are compacted.
  always_comb begin
    cut        = 1'b0;
    has_pred   = 1'b0;
    have_first = 1'b0;
    n_kept     = '0;
    pred_tgt   = '0;
    replay_addr_o = '0;
    for (int i = 0; i < int'(LANES); i++) packed_q[i] = '0;
    for (int i = 0; i < int'(LANES); i++) begin
      kept[i] = valid_i[i] && !cut;
      if (kept[i]) begin
        packed_q[n_kept] = lane_i[i];
        n_kept           = n_kept + 1'b1;
        if (!have_first) begin
          replay_addr_o = lane_i[i].addr;
          have_first    = 1'b1;
        end
        if (lane_i[i].pred) begin
          cut      = 1'b1;
          has_pred = 1'b1;
          pred_tgt = target_i[i*IQ_XLEN +: IQ_XLEN];
        end
      end
    end
  end

  always_comb begin
    fits_iq  = (int'(IQ_DEPTH) - int'(iq_count_i)) >= int'(n_kept);
    fits_aq  = !has_pred || (int'(aq_count_i) < int'(AQ_DEPTH));
    take     = !flush_i && have_first && fits_iq && fits_aq;
    replay_o = !flush_i && have_first && !take;
    iq_push_n_o    = take ? n_kept : '0;
    aq_push_o      = take && has_pred;
    aq_push_data_o = pred_tgt;
    for (int k = 0; k < int'(LANES); k++) begin
      iq_push_data_o[k*IQ_ENTRY_W +: IQ_ENTRY_W] = packed_q[k];
    end
  end
endmodule

// File: rtl/iq_queue.sv
module iq_queue
  import iq_pkg::*;
#(
  parameter int unsigned LANES    = 2,
  parameter int unsigned AQ_DEPTH = 2,
  localparam int unsigned IQ_DEPTH = 4 * LANES,
  localparam int unsigned NW       = $clog2(LANES + 1),
  localparam int unsigned ICW      = $clog2(IQ_DEPTH + 1),
  localparam int unsigned ACW      = $clog2(AQ_DEPTH + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic [LANES-1:0]              in_valid_i,
  input  logic [LANES*IQ_ILEN-1:0]      in_instr_i,
  input  logic [LANES*IQ_XLEN-1:0]      in_addr_i,
  input  logic [LANES*IQ_CF_W-1:0]      in_cf_i,
  input  logic [LANES-1:0]              in_exc_i,
  input  logic [LANES*IQ_CAUSE_W-1:0]   in_exc_cause_i,
  input  logic [LANES*IQ_XLEN-1:0]      in_exc_tval_i,
  input  logic [LANES-1:0]              in_pred_i,
  input  logic [LANES*IQ_XLEN-1:0]      in_pred_target_i,
  output logic                          replay_o,
  output logic [IQ_XLEN-1:0]            replay_addr_o,
  output logic                          out_valid_o,
  input  logic                          out_ready_i,
  output logic [IQ_ILEN-1:0]            out_instr_o,
  output logic [IQ_XLEN-1:0]            out_addr_o,
  output logic [IQ_CF_W-1:0]            out_cf_o,
  output logic                          out_exc_o,
  output logic [IQ_CAUSE_W-1:0]         out_exc_cause_o,
  output logic [IQ_XLEN-1:0]            out_exc_tval_o,
  output logic                          out_pred_valid_o,
  output logic [IQ_XLEN-1:0]            out_pred_target_o
);
  iq_entry_t                   lane_ent [LANES];
  logic [NW-1:0]               iq_push_n;
  logic [LANES*IQ_ENTRY_W-1:0] iq_push_data;
  logic                        aq_push;
  logic [IQ_XLEN-1:0]          aq_push_data, aq_head;
  logic [IQ_ENTRY_W-1:0]       iq_head_raw;
  iq_entry_t                   head;
  logic [ICW-1:0]              iq_cnt;
  logic [ACW-1:0]              aq_cnt;
  logic                        iq_pop, aq_pop;

  always_comb begin
    for (int i = 0; i < int'(LANES); i++) begin
      lane_ent[i].instr = in_instr_i[i*IQ_ILEN +: IQ_ILEN];
      lane_ent[i].addr  = in_addr_i[i*IQ_XLEN +: IQ_XLEN];
      lane_ent[i].cf    = iq_cf_e'(in_cf_i[i*IQ_CF_W +: IQ_CF_W]);
      lane_ent[i].exc   = in_exc_i[i];
      lane_ent[i].cause = in_exc_cause_i[i*IQ_CAUSE_W +: IQ_CAUSE_W];
      lane_ent[i].tval  = in_exc_tval_i[i*IQ_XLEN +: IQ_XLEN];
      lane_ent[i].pred  = in_pred_i[i];
    end
  end

  iq_admit #(.LANES(LANES), .IQ_DEPTH(IQ_DEPTH), .AQ_DEPTH(AQ_DEPTH)) u_admit (
    .flush_i        (flush_i),
    .valid_i        (in_valid_i),
    .lane_i         (lane_ent),
    .target_i       (in_pred_target_i),
    .iq_count_i     (iq_cnt),
    .aq_count_i     (aq_cnt),
    .iq_push_n_o    (iq_push_n),
    .iq_push_data_o (iq_push_data),
    .aq_push_o      (aq_push),
    .aq_push_data_o (aq_push_data),
    .replay_o       (replay_o),
    .replay_addr_o  (replay_addr_o)
  );

  iq_ring #(.W(IQ_ENTRY_W), .DEPTH(IQ_DEPTH), .NPUSH(LANES)) u_instr_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .push_n_i    (iq_push_n),
    .push_data_i (iq_push_data),
    .pop_i       (iq_pop),
    .head_o      (iq_head_raw),
    .count_o     (iq_cnt)
  );

  iq_ring #(.W(IQ_XLEN), .DEPTH(AQ_DEPTH), .NPUSH(1)) u_target_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .push_n_i    (aq_push),
    .push_data_i (aq_push_data),
    .pop_i       (aq_pop),
    .head_o      (aq_head),
    .count_o     (aq_cnt)
  );

  assign head        = iq_entry_t'(iq_head_raw);
  assign out_valid_o = (iq_cnt != '0);
  assign iq_pop      = out_valid_o && out_ready_i && !flush_i;
  assign aq_pop      = iq_pop && head.pred;

  assign out_instr_o       = head.instr;
  assign out_addr_o        = head.addr;
  assign out_cf_o          = head.cf;
  assign out_exc_o         = head.exc;
  assign out_exc_cause_o   = head.cause;
  assign out_exc_tval_o    = head.tval;
  assign out_pred_valid_o  = out_valid_o && head.pred;
  assign out_pred_target_o = out_pred_valid_o ? aq_head : '0;
endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
  parameter int unsigned LANES    = 2,
  parameter int unsigned IQ_DEPTH = 8,
  parameter int unsigned AQ_DEPTH = 2,
  localparam int unsigned ICW     = $clog2(IQ_DEPTH + 1),
  localparam int unsigned ACW     = $clog2(AQ_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic [LANES-1:0] in_valid_i,
  input logic             replay_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [31:0]      out_instr_o,
  input logic             out_pred_valid_o,
  input logic [31:0]      out_pred_target_o,
  input logic [ICW-1:0]   iq_count,
  input logic [ACW-1:0]   aq_count
);
  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_IDLE: assert (!out_valid_o); // R1
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) iq_count <= ICW'(IQ_DEPTH)); // R3
  AST_TARGET_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) aq_count <= ACW'(AQ_DEPTH)); // R5
  AST_TARGET_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni) int'(aq_count) <= int'(iq_count)); // R7
  AST_REPLAY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni) replay_o |-> ((|in_valid_i) && !flush_i)); // R4
  AST_HOLD_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni) (out_valid_o && !out_ready_i && !flush_i) |=> (out_valid_o && $stable(out_instr_o))); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni) flush_i |=> (iq_count == '0 && aq_count == '0)); // R9
  AST_TARGET_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni) !out_pred_valid_o |-> (out_pred_target_o == '0)); // R7
endmodule

bind iq_queue iq_checker #(.LANES(LANES), .IQ_DEPTH(IQ_DEPTH), .AQ_DEPTH(AQ_DEPTH)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .flush_i           (flush_i),
  .in_valid_i        (in_valid_i),
  .replay_o          (replay_o),
  .out_valid_o       (out_valid_o),
  .out_ready_i       (out_ready_i),
  .out_instr_o       (out_instr_o),
  .out_pred_valid_o  (out_pred_valid_o),
  .out_pred_target_o (out_pred_target_o),
  .iq_count          (iq_cnt),
  .aq_count          (aq_cnt)
);

// File: tb/sim_iq_queue.sv
module sim_iq_queue;
  import iq_pkg::*;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic flush_i;
  logic [1:0]  in_valid_i, in_exc_i, in_pred_i;
  logic [63:0] in_instr_i, in_addr_i, in_exc_tval_i, in_pred_target_i;
  logic [5:0]  in_cf_i;
  logic [11:0] in_exc_cause_i;
  logic        replay_o, out_valid_o, out_ready_i, out_exc_o, out_pred_valid_o;
  logic [31:0] replay_addr_o, out_instr_o, out_addr_o, out_exc_tval_o, out_pred_target_o;
  logic [2:0]  out_cf_o;
  logic [5:0]  out_exc_cause_o;

  always #10 clk_i = ~clk_i;

  iq_queue u0 (.*);

  typedef struct {
    logic [31:0] instr, addr, tval, tgt;
    logic [2:0]  cf;
    logic        exc, pred;
    logic [5:0]  cause;
  } mdl_t;

  mdl_t mq[$];
  mdl_t bl[2];
  logic bv[2];
  int   checks = 0, fails = 0;
  bit   held = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic apply();
    for (int i = 0; i < 2; i++) begin
      in_valid_i[i]              = bv[i];
      in_instr_i[i*32 +: 32]     = bl[i].instr;
      in_addr_i[i*32 +: 32]      = bl[i].addr;
      in_cf_i[i*3 +: 3]          = bl[i].cf;
      in_exc_i[i]                = bl[i].exc;
      in_exc_cause_i[i*6 +: 6]   = bl[i].cause;
      in_exc_tval_i[i*32 +: 32]  = bl[i].tval;
      in_pred_i[i]               = bl[i].pred;
      in_pred_target_i[i*32 +: 32] = bl[i].tgt;
    end
  endtask

  task automatic set_block(input bit v0, input bit v1, input bit p0, input bit p1);
    logic [31:0] base;
    base = $urandom() & 32'hFFFF_FFFC;
    for (int i = 0; i < 2; i++) begin
      bl[i].instr = $urandom();
      bl[i].addr  = base + 32'(4 * i);
      bl[i].cf    = 3'($urandom_range(0, 4));
      bl[i].exc   = ($urandom_range(0, 7) == 0);
      bl[i].cause = 6'($urandom());
      bl[i].tval  = $urandom();
      bl[i].tgt   = $urandom() | 32'h1;
    end
    bv[0] = v0; bv[1] = v1;
    bl[0].pred = p0; bl[1].pred = p1;
  endtask

  function automatic int pred_count();
    int c = 0;
    foreach (mq[k]) if (mq[k].pred) c++;
    return c;
  endfunction

  // One cycle: inputs already set at the falling edge; check, then advance the model.
  task automatic step(input bit rdy, input string rtag);
    bit cut, hp, rep, exp_ov;
    int n;
    logic [31:0] faddr;
    mdl_t keep[$];
    string htag;
    out_ready_i = rdy;
    apply();
    #1;
    htag = held ? "R8" : "R2";
    exp_ov = (mq.size() != 0);
    chk(out_valid_o == exp_ov, htag, 64'(out_valid_o), 64'(exp_ov));
    if (exp_ov) begin
      chk(out_instr_o == mq[0].instr, htag, 64'(out_instr_o), 64'(mq[0].instr));
      chk(out_addr_o == mq[0].addr, htag, 64'(out_addr_o), 64'(mq[0].addr));
      chk(out_cf_o == mq[0].cf && out_exc_o == mq[0].exc && out_exc_cause_o == mq[0].cause,
          htag, {out_cf_o, out_exc_o, out_exc_cause_o}, {mq[0].cf, mq[0].exc, mq[0].cause});
      chk(out_exc_tval_o == mq[0].tval, htag, 64'(out_exc_tval_o), 64'(mq[0].tval));
      chk(out_pred_valid_o == mq[0].pred, "R7", 64'(out_pred_valid_o), 64'(mq[0].pred));
      chk(out_pred_target_o == (mq[0].pred ? mq[0].tgt : 32'h0), "R7",
          64'(out_pred_target_o), 64'(mq[0].pred ? mq[0].tgt : 32'h0));
    end
    cut = 0; hp = 0; n = 0; faddr = '0;
    for (int i = 0; i < 2; i++) begin
      if (bv[i] && !cut) begin
        if (n == 0) faddr = bl[i].addr;
        keep.push_back(bl[i]);
        n++;
        if (bl[i].pred) begin cut = 1; hp = 1; end
      end
    end
    rep = !flush_i && (n > 0) && ((8 - mq.size() < n) || (hp && pred_count() >= 2));
    chk(replay_o == rep, flush_i ? "R9" : rtag, 64'(replay_o), 64'(rep));
    if (rep) chk(replay_addr_o == faddr, rtag, 64'(replay_addr_o), 64'(faddr));
    held = exp_ov && !rdy && !flush_i;
    if (flush_i) mq.delete();
    else begin
      if (rdy && exp_ov) void'(mq.pop_front());
      if (!rep) foreach (keep[k]) mq.push_back(keep[k]);
    end
    @(negedge clk_i);
  endtask

  task automatic idle(input bit rdy, input string rtag);
    set_block(0, 0, 0, 0);
    step(rdy, rtag);
  endtask

  task automatic do_flush();
    flush_i = 1'b1;
    set_block(1, 1, 0, 0);
    step(1'b0, "R9");
    flush_i = 1'b0;
    apply();
    #1;
    chk(out_valid_o == 1'b0, "R9", 64'(out_valid_o), 64'h0);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_ni = 1'b0; flush_i = 1'b0; out_ready_i = 1'b0;
    set_block(1, 1, 0, 0);
    apply();
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1", 64'(out_valid_o), 64'h0);
    rst_ni = 1'b1;
    set_block(0, 0, 0, 0);
    apply();
    #1;
    chk(out_valid_o == 1'b0 && replay_o == 1'b0, "R1", {out_valid_o, replay_o}, 64'h0);
    @(negedge clk_i);

    // R6: lane 0 predicted, lane 1 valid -> only lane 0 queued
    set_block(1, 1, 1, 0);
    step(1'b0, "R6");
    idle(1'b1, "R6");
    apply(); #1;
    chk(out_valid_o == 1'b0, "R6", 64'(out_valid_o), 64'h0);

    // R3: occupancy 7, then a two-wide block (rejected), then one-wide (accepted)
    for (int b = 0; b < 3; b++) begin set_block(1, 1, 0, 0); step(1'b0, "R3"); end
    set_block(0, 1, 0, 0); step(1'b0, "R3");
    set_block(1, 1, 0, 0); step(1'b0, "R3");
    set_block(1, 0, 0, 0); step(1'b0, "R3");
    // R10: empty block with a full queue
    idle(1'b0, "R10");
    do_flush();

    // R5: two predictions queued, target FIFO full
    set_block(1, 0, 1, 0); step(1'b0, "R5");
    set_block(0, 1, 0, 1); step(1'b0, "R5");
    set_block(1, 1, 1, 0); step(1'b0, "R5");
    set_block(1, 1, 0, 0); step(1'b0, "R5");
    for (int d = 0; d < 6; d++) idle(1'b1, "R4");
    do_flush();

    // Random traffic
    for (int c = 0; c < 4000; c++) begin
      flush_i = ($urandom_range(0, 63) == 0);
      set_block($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
      step($urandom_range(0, 9) < 4, "R4");
      flush_i = 1'b0;
    end
    for (int d = 0; d < 10; d++) idle(1'b1, "R4");
    finish_run();
  end
endmodule